// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor's program sequencer and decides which of eight interrupt slots is served next. Three of the slots take active-low request lines from outside the core. Each of these lines is synchronized and can be set to react to a falling edge or to a held low level. Three more slots latch one-cycle event pulses from units inside the core: an interval timer and two serial-port events. The last two slots are software interrupts. Nothing in hardware raises them; they become pending only when software sets their force bits.

Software programs the block through a single write port with three targets. The first is a ten-bit enable mask. The second is a sixteen-bit register whose low byte clears pending slots and whose high byte forces them pending. The third is a control word that picks edge or level sensing for each external line and turns nesting on or off. Among the slots that are requested and enabled, the block picks the one with the lowest vector address. It presents that address with a valid flag in the same cycle it evaluates the state. An acknowledge from the sequencer moves the winner into service. A return pulse ends the service of the innermost active slot.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the mask is all zero, no slot is pending or in service, all external lines are level-sensitive, nesting is off, and `vec_valid` is 0.
- R2: Each slot has a fixed vector address. Slot 7 (external line 2) is 0x0004, slot 6 (core event 2) 0x0008, slot 5 (core event 1) 0x000C, slot 4 (software 1) 0x0018, slot 3 (software 0) 0x001C, slot 2 (external line 1) 0x0020, slot 1 (external line 0) 0x0024 and slot 0 (core event 0, timer) 0x0028. When several slots are eligible, the lowest address is issued.
- R3: Writes with `cfg_sel`=0 load the mask. Slots 0–6 are enabled by mask bits 0–6 and slot 7 by mask bit 9; bits 7 and 8 enable nothing. A pending slot whose mask bit is 0 is not issued but stays pending.
- R4: Writes with `cfg_sel`=1 update the force/clear register. A 1 in bit i (0–7) clears pending slot i, a 1 in bit i+8 sets it pending, a 0 changes nothing, and a force wins over a clear of the same slot in the same write.
- R5: Software slots 3 and 4 become pending only through force bits 11 and 12. No external line and no core event raises them.
- R6: Control bits 0, 1 and 2 (`cfg_sel`=2) select edge sensing (1) for external lines 0, 1 and 2. In edge mode, a falling edge on the line makes the slot issuable on the third rising clock edge after the line falls. The slot then stays pending after the line rises, until an acknowledge clears it.
- R7: In level mode, an external line requests its slot on the second rising edge after going low, for as long as it stays low, and is never latched. A low pulse that ends while the slot is masked leaves nothing pending.
- R8: A one-cycle high on `core_evt[0]`, `core_evt[1]` or `core_evt[2]` latches slot 0, 5 or 6 pending.
- R9: An acknowledge while `vec_valid` is 1 clears the issued slot's pending bit and puts that slot in service. An acknowledge while `vec_valid` is 0 has no effect.
- R10: With nesting off (control bit 4 = 0), no vector is issued while any slot is in service. `rti` ends that service.
- R11: With nesting on, a slot preempts only if its priority is strictly higher than the innermost slot in service. `rti` ends the innermost service, and the next outer slot again blocks anything not above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xirq_n | input | 3 | Asynchronous external request lines, active low (bit 0 → slot 1, bit 1 → slot 2, bit 2 → slot 7) |
| core_evt | input | 3 | One-cycle core event pulses (bit 0 → slot 0, bit 1 → slot 5, bit 2 → slot 6) |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 mask, 1 force/clear, 2 control, 3 none |
| cfg_wdata | input | 16 | Write data |
| vec_ack | input | 1 | Sequencer accepts the presented vector |
| rti | input | 1 | Return from the innermost interrupt service |
| vec_valid | output | 1 | A vector is being offered |
| vec_addr | output | VEC_W | Offered vector address, zero when not valid |

## Verification
The hardest state to reach is a two-deep nesting stack in which a request at the same priority as the outer service waits behind it. Reaching it takes a low-priority slot in service, a higher-priority preemption on top of it, and a fresh force of the outer slot's own pending bit. The stimulus builds this from force writes and acknowledges. It then unwinds the stack with `rti` pulses and checks after each pulse that the equal-priority slot stays blocked until its own service has ended. Sampling the edge-sensing latency is the other delicate point. The bench drops an external line at a known falling clock edge and checks the output both one edge before and on the edge on which the slot should first appear.

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int VEC_W  = 16,
  parameter int MASK_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       xirq_n,
  input  logic [2:0]       core_evt,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [15:0]      cfg_wdata,
  input  logic             vec_ack,
  input  logic             rti,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_addr
);

  logic [2:0]        sy1, sy2, sy3;
  logic [MASK_W-1:0] mask_q;
  logic [2:0]        edge_q;
  logic              nest_q;
  logic [7:0]        pend_q, act_q;
  logic [2:0]        win, top;
  logic              hit;

  wire [7:0] mask8   = {mask_q[9], mask_q[6:0]};
  wire [2:0] fall    = sy3 & ~sy2 & edge_q;
  wire [2:0] lvl     = ~sy2 & ~edge_q;
  wire [7:0] ext_set = {fall[2], 4'b0, fall[1], fall[0], 1'b0};
  wire [7:0] lvl_req = {lvl[2], 4'b0, lvl[1], lvl[0], 1'b0};
  wire [7:0] evt_set = {1'b0, core_evt[2], core_evt[1], 4'b0, core_evt[0]};
  wire [7:0] req     = (pend_q | lvl_req) & mask8;
  wire       busy    = |act_q;

  always_comb begin
    win = 3'd0;
    hit = 1'b0;
    for (int i = 0; i < 8; i++)
      if (req[i]) begin
        win = 3'(i);
        hit = 1'b1;
      end
  end

  always_comb begin
    top = 3'd0;
    for (int i = 0; i < 8; i++)
      if (act_q[i]) top = 3'(i);
  end

  function automatic logic [VEC_W-1:0] slot_vec(input logic [2:0] s);
    case (s)
      3'd7:    slot_vec = VEC_W'(16'h0004);
      3'd6:    slot_vec = VEC_W'(16'h0008);
      3'd5:    slot_vec = VEC_W'(16'h000C);
      3'd4:    slot_vec = VEC_W'(16'h0018);
      3'd3:    slot_vec = VEC_W'(16'h001C);
      3'd2:    slot_vec = VEC_W'(16'h0020);
      3'd1:    slot_vec = VEC_W'(16'h0024);
      default: slot_vec = VEC_W'(16'h0028);
    endcase
  endfunction

  wire       allow  = hit & (~busy | (nest_q & (win > top)));
  wire       take   = vec_ack & allow;
  wire       pop    = rti & busy;
  wire [7:0] win_oh = 8'b1 << win;
  wire [7:0] top_oh = 8'b1 << top;
  wire       wr_fc  = cfg_we && cfg_sel == 2'd1;
  wire [7:0] clr    = wr_fc ? cfg_wdata[7:0]  : 8'h00;
  wire [7:0] frc    = wr_fc ? cfg_wdata[15:8] : 8'h00;

  assign vec_valid = allow;
  assign vec_addr  = allow ? slot_vec(win) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= 3'b111;
      sy2 <= 3'b111;
      sy3 <= 3'b111;
    end else begin
      sy1 <= xirq_n;
      sy2 <= sy1;
      sy3 <= sy2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q <= '0;
      edge_q <= '0;
      nest_q <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_sel == 2'd0) mask_q <= cfg_wdata[MASK_W-1:0];
      if (cfg_sel == 2'd2) begin
        edge_q <= cfg_wdata[2:0];
        nest_q <= cfg_wdata[4];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr & ~(take ? win_oh : 8'h00)) | frc | ext_set | evt_set;
      act_q  <= (act_q & ~(pop ? top_oh : 8'h00)) | (take ? win_oh : 8'h00);
    end

endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vec_valid,
  input logic       vec_ack,
  input logic       rti,
  input logic       nest,
  input logic [7:0] act,
  input logic [2:0] win,
  input logic [7:0] mask8
);

  logic [2:0] inner;
  always_comb begin
    inner = 3'd0;
    for (int i = 0; i < 8; i++)
      if (act[i]) inner = 3'(i);
  end

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest && act != 8'h00) |-> !vec_valid); // R10

  AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && act != 8'h00) |-> (nest && win > inner)); // R11

  AST_ACK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && vec_valid) |=> act[$past(win)]); // R9

  AST_ISSUE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> mask8[win]); // R3

  AST_RTI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && !vec_ack && act != 8'h00) |=> ($countones(act) == $countones($past(act)) - 1)); // R11

endmodule

bind prio_vec_intc prio_vec_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ack(vec_ack), .rti(rti),
  .nest(nest_q), .act(act_q), .win(win), .mask8(mask8)
);

// File: tb/prio_vec_intc_tb_top.sv
`timescale 1ns/1ps
module prio_vec_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  xirq_n = 3'b111;
  logic [2:0]  core_evt = 3'b000;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'h0000;
  logic        vec_ack = 1'b0;
  logic        rti = 1'b0;
  logic        vec_valid;
  logic [15:0] vec_addr;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_vec_intc dut_i (
    .clk(clk), .rst_n(rst_n), .xirq_n(xirq_n), .core_evt(core_evt),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .vec_ack(vec_ack), .rti(rti), .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  task automatic chk(input string tag, input logic ev, input logic [15:0] ea);
    n_chk++;
    if (vec_valid !== ev || (ev && vec_addr !== ea)) begin
      n_err++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               tag, vec_valid, vec_addr, ev, ea);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ack();
    vec_ack = 1'b1; @(negedge clk); vec_ack = 1'b0;
  endtask

  task automatic ret();
    rti = 1'b1; @(negedge clk); rti = 1'b0;
  endtask

  task automatic evt(input logic [2:0] e);
    core_evt = e; @(negedge clk); core_evt = 3'b000;
  endtask

  function automatic logic [15:0] exp_vec(input int k);
    case (k)
      0: exp_vec = 16'h0004; 1: exp_vec = 16'h0008; 2: exp_vec = 16'h000C;
      3: exp_vec = 16'h0018; 4: exp_vec = 16'h001C; 5: exp_vec = 16'h0020;
      6: exp_vec = 16'h0024; default: exp_vec = 16'h0028;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 idle after reset", 1'b0, 16'h0);
    wr(1, 16'h8000);
    chk("R1 mask zero after reset", 1'b0, 16'h0);
    wr(1, 16'h0080);
  endtask

  task automatic t_force_clear();
    wr(0, 16'h03FF);
    wr(1, 16'h0100);
    chk("R4 force slot0", 1'b1, 16'h0028);
    wr(1, 16'h0000);
    chk("R4 zero write no effect", 1'b1, 16'h0028);
    wr(1, 16'h0001);
    chk("R4 clear slot0", 1'b0, 16'h0);
    wr(1, 16'h0101);
    chk("R4 force wins over clear", 1'b1, 16'h0028);
    wr(1, 16'h0001);
  endtask

  task automatic t_priority();
    wr(1, 16'hFF00);
    for (int k = 0; k < 8; k++) begin
      chk("R2 priority order", 1'b1, exp_vec(k));
      ack();
      chk("R10 blocked in service", 1'b0, 16'h0);
      ret();
    end
    chk("R2 all served", 1'b0, 16'h0);
  endtask

  task automatic t_mask();
    wr(0, 16'h0000);
    wr(1, 16'h8000);
    chk("R3 masked slot7", 1'b0, 16'h0);
    wr(0, 16'h01FF);
    chk("R3 bits0-8 do not enable slot7", 1'b0, 16'h0);
    wr(0, 16'h0200);
    chk("R3 bit9 enables slot7", 1'b1, 16'h0004);
    wr(1, 16'h0080);
    wr(1, 16'h4000);
    chk("R3 slot6 masked", 1'b0, 16'h0);
    wr(0, 16'h0040);
    chk("R3 slot6 by bit6", 1'b1, 16'h0008);
    wr(1, 16'h0040);
    wr(0, 16'h03FF);
  endtask

  task automatic t_soft();
    wr(0, 16'h0018);
    evt(3'b111);
    xirq_n = 3'b000;
    idle(4);
    xirq_n = 3'b111;
    idle(3);
    chk("R5 no hardware source raises software slots", 1'b0, 16'h0);
    wr(1, 16'h00FF);
    wr(1, 16'h0800);
    chk("R5 force bit 11", 1'b1, 16'h001C);
    wr(1, 16'h0008);
    wr(1, 16'h1000);
    chk("R5 force bit 12", 1'b1, 16'h0018);
    wr(1, 16'h0010);
    wr(0, 16'h03FF);
  endtask

  task automatic t_edge();
    wr(2, 16'h0007);
    wr(0, 16'h0002);
    xirq_n[0] = 1'b0;
    idle(2);
    chk("R6 not yet after two edges", 1'b0, 16'h0);
    idle(1);
    chk("R6 issued on third edge", 1'b1, 16'h0024);
    xirq_n[0] = 1'b1;
    idle(3);
    chk("R6 latched after line rises", 1'b1, 16'h0024);
    ack();
    chk("R6 acked", 1'b0, 16'h0);
    ret();
    chk("R6 cleared by ack", 1'b0, 16'h0);
  endtask

  task automatic t_level();
    wr(2, 16'h0000);
    wr(0, 16'h0200);
    xirq_n[2] = 1'b0;
    idle(1);
    chk("R7 not yet after one edge", 1'b0, 16'h0);
    idle(1);
    chk("R7 level request", 1'b1, 16'h0004);
    ack();
    chk("R7 in service", 1'b0, 16'h0);
    ret();
    chk("R7 still low re-requests", 1'b1, 16'h0004);
    xirq_n[2] = 1'b1;
    idle(2);
    chk("R7 released", 1'b0, 16'h0);
    wr(0, 16'h0000);
    xirq_n[2] = 1'b0;
    idle(3);
    xirq_n[2] = 1'b1;
    idle(3);
    wr(0, 16'h0200);
    chk("R7 masked pulse not latched", 1'b0, 16'h0);
  endtask

  task automatic t_core();
    wr(0, 16'h0061);
    evt(3'b001);
    chk("R8 timer event", 1'b1, 16'h0028);
    evt(3'b100);
    chk("R8 event2 outranks timer", 1'b1, 16'h0008);
    ack(); ret();
    chk("R8 timer still pending", 1'b1, 16'h0028);
    ack(); ret();
    evt(3'b010);
    chk("R8 event1", 1'b1, 16'h000C);
    ack(); ret();
    chk("R8 drained", 1'b0, 16'h0);
  endtask

  task automatic t_ack_idle();
    ack();
    wr(1, 16'h0100);
    chk("R9 stray ack ignored", 1'b1, 16'h0028);
    ack();
    chk("R9 ack takes slot", 1'b0, 16'h0);
    ret();
    chk("R9 ack cleared pending", 1'b0, 16'h0);
  endtask

  task automatic t_nest_off();
    wr(0, 16'h03FF);
    wr(2, 16'h0000);
    wr(1, 16'h0100);
    ack();
    wr(1, 16'h8000);
    chk("R10 higher blocked without nesting", 1'b0, 16'h0);
    ret();
    chk("R10 issued after rti", 1'b1, 16'h0004);
    ack(); ret();
    chk("R10 drained", 1'b0, 16'h0);
  endtask

  task automatic t_nest_on();
    wr(2, 16'h0010);
    wr(1, 16'h0800);
    chk("R11 outer issue", 1'b1, 16'h001C);
    ack();
    wr(1, 16'h0100);
    chk("R11 lower waits", 1'b0, 16'h0);
    wr(1, 16'h1000);
    chk("R11 higher preempts", 1'b1, 16'h0018);
    ack();
    chk("R11 nested in service", 1'b0, 16'h0);
    wr(1, 16'h0800);
    chk("R11 below inner waits", 1'b0, 16'h0);
    ret();
    chk("R11 equal to outer waits", 1'b0, 16'h0);
    ret();
    chk("R11 after outer ends", 1'b1, 16'h001C);
    ack(); ret();
    chk("R11 lowest last", 1'b1, 16'h0028);
    ack(); ret();
    chk("R11 drained", 1'b0, 16'h0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_force_clear();
    t_priority();
    t_mask();
    t_soft();
    t_edge();
    t_level();
    t_core();
    t_ack_idle();
    t_nest_off();
    t_nest_on();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule